// File: doc/BRIEF.md
# I2C Slave Address Responder

This block is the target-side engine of a byte-oriented I2C controller. It watches the open-drain clock and data lines, finds a START, and shifts in the first byte that follows. Bits 7 to 1 of that byte are compared with a 7-bit own address. On a match it pulls SDA low for the acknowledge clock. It then records that it has been selected and latches the direction bit. From that point it serves data bytes one at a time through a local data register.

After every byte it keeps, the block stretches the clock. It pulls SCL low and raises an interrupt. Local software services the data register in the transfer direction to let the clock run again. In receive direction that means a read, and the first read after the address is a dummy that starts the transfer. In transmit direction it means a write, which loads the next byte to send. Because of this hold, the remote master and local software can handle their end-of-byte work in either order and no byte is lost. The block never drives START, STOP or clock pulses of its own.

Top module: `i2cs_addr_resp`

## Requirements
- R1: After reset both line pulls are released, every status bit is 0 and the interrupt is low.
- R2: When bits 7..1 of the first byte after a START equal `own_addr_i`, the block pulls SDA low during the ninth clock, sets status bit 6 (selected) and raises the interrupt.
- R3: When the address does not match, SDA stays released on the ninth clock, status bit 6 stays 0, no interrupt is raised, and later bytes of that block get no acknowledge and no clock stretch, until the next START or STOP.
- R4: Status bit 2 holds bit 0 of the matched address byte (1 = the block transmits, 0 = it receives) and does not change while the block stays selected.
- R5: After the acknowledge of a matched address, of a received byte, or of a transmitted byte that the master acknowledged, SCL is pulled low. It stays low until a data read (receive direction) or a data write (transmit direction). An access of the other kind does not release it.
- R6: In receive direction every data byte gets an acknowledge (SDA low on the ninth clock), and `rd_data_o` shows the byte, MSB first on the wire, from the end of its eighth bit onward.
- R7: In transmit direction status bit 4 is 1 and the written byte is driven MSB first. The master's ninth-clock bit is sampled, and when it is 0 (acknowledge) the block stretches the clock for the next byte.
- R8: When the master leaves the ninth bit of a transmitted byte at 1 (no acknowledge), status bit 0 is set and the interrupt is raised. Status bit 4 clears (back to receive mode), both lines stay released, and the block waits for a new START.
- R9: A STOP clears status bit 6 and returns the block to waiting for a START.
- R10: The interrupt (also status bit 1) is set at each clock-stretch entry and at a missing master acknowledge, and it is cleared by any single-cycle data read or write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, oversamples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the shared clock line |
| sda_i | input | 1 | Sensed level of the shared data line |
| scl_pull_o | output | 1 | 1 pulls the clock line low (stretch) |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge or a 0 data bit) |
| own_addr_i | input | ADDR_W | Programmed 7-bit own address |
| wr_stb_i | input | 1 | Single-cycle data register write |
| wr_data_i | input | BYTE_W | Byte to transmit |
| rd_stb_i | input | 1 | Single-cycle data register read |
| rd_data_o | output | BYTE_W | Last received byte |
| status_o | output | 8 | Bit 6 selected, bit 4 transmit mode, bit 2 direction, bit 1 interrupt, bit 0 missing acknowledge |
| irq_o | output | 1 | End-of-byte interrupt |

## Verification
The properties assume a bus that keeps I2C line rules. SDA moves only while SCL is low, apart from START and STOP. The master waits for SCL to read high before it goes on, so it never tries a START or STOP while the block holds the clock. Register strobes last one cycle. The bench master meets these rules. It changes SDA ten block cycles after each falling clock edge, well past the synchronizer and filter latency. It reads the bus level of SCL before it starts each high phase. Software accesses are pulses of one cycle, given only while the bus is idle or stretched.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

   typedef enum logic [2:0] {
      RS_WAIT   = 3'd0,
      RS_ADDR   = 3'd1,
      RS_ACKW   = 3'd2,
      RS_ACKD   = 3'd3,
      RS_HOLD   = 3'd4,
      RS_RX     = 3'd5,
      RS_TX     = 3'd6,
      RS_TACK   = 3'd7
   } rsp_state_t;

   localparam int STB_NACK  = 0;
   localparam int STB_IRQ   = 1;
   localparam int STB_DIR   = 2;
   localparam int STB_TXM   = 4;
   localparam int STB_SEL   = 6;

endpackage

// File: rtl/i2cs_line_cond.sv
module i2cs_line_cond #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYC    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   generate
      if (FILT_CYC == 0) begin : g_bypass
         assign line_o = sync_q[SYNC_STAGES-1];
      end else begin : g_filter
         localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);
         localparam logic [CW-1:0] LIM = CW'(FILT_CYC - 1);
         logic [CW-1:0] run_q;
         logic          lvl_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
               lvl_q <= 1'b1;
            end else if (sync_q[SYNC_STAGES-1] != lvl_q) begin
               if (run_q == LIM) begin
                  lvl_q <= sync_q[SYNC_STAGES-1];
                  run_q <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end else begin
               run_q <= '0;
            end
         end

         assign line_o = lvl_q;
      end
   endgenerate

endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_c,
   input  logic sda_c,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_c;
         sda_q <= sda_c;
      end
   end

   assign scl_rise  =  scl_c & ~scl_q;
   assign scl_fall  = ~scl_c &  scl_q;
   assign start_det =  scl_c &  scl_q &  sda_q & ~sda_c;
   assign stop_det  =  scl_c &  scl_q & ~sda_q &  sda_c;

endmodule

// File: rtl/i2cs_byte_fsm.sv
module i2cs_byte_fsm
   import i2cs_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_lvl,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              wr_stb,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_stb,
   output logic [BYTE_W-1:0] rd_data,
   output logic              scl_pull,
   output logic              sda_pull,
   output logic              selected,
   output logic              dir_tx,
   output logic              tx_mode,
   output logic              nack,
   output logic              irq
);

   localparam int CW = $clog2(BYTE_W);
   localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

   rsp_state_t        state_q;
   logic [CW-1:0]     cnt_q;
   logic [BYTE_W-1:0] sh_q;
   logic [BYTE_W-1:0] shifted;
   logic              irq_set;
   logic              any_access;

   assign shifted    = {sh_q[BYTE_W-2:0], sda_lvl};
   assign any_access = wr_stb | rd_stb;
   assign irq_set    = ((state_q == RS_ACKD) || (state_q == RS_TACK)) && scl_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          irq <= 1'b0;
      else if (irq_set)    irq <= 1'b1;
      else if (any_access) irq <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= RS_WAIT;
         cnt_q    <= '0;
         sh_q     <= '0;
         rd_data  <= '0;
         scl_pull <= 1'b0;
         sda_pull <= 1'b0;
         selected <= 1'b0;
         dir_tx   <= 1'b0;
         tx_mode  <= 1'b0;
         nack     <= 1'b0;
      end else if (start_det) begin
         state_q  <= RS_ADDR;
         cnt_q    <= '0;
         scl_pull <= 1'b0;
         sda_pull <= 1'b0;
         selected <= 1'b0;
         tx_mode  <= 1'b0;
         nack     <= 1'b0;
      end else if (stop_det) begin
         state_q  <= RS_WAIT;
         cnt_q    <= '0;
         scl_pull <= 1'b0;
         sda_pull <= 1'b0;
         selected <= 1'b0;
         tx_mode  <= 1'b0;
      end else begin
         case (state_q)
            RS_WAIT: ;
            RS_ADDR: begin
               if (scl_rise) begin
                  sh_q <= shifted;
                  if (cnt_q == LAST) begin
                     cnt_q <= '0;
                     if (shifted[BYTE_W-1:1] == own_addr) begin
                        selected <= 1'b1;
                        dir_tx   <= shifted[0];
                        tx_mode  <= shifted[0];
                        state_q  <= RS_ACKW;
                     end else begin
                        state_q  <= RS_WAIT;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            RS_ACKW: begin
               if (scl_fall) begin
                  sda_pull <= 1'b1;
                  state_q  <= RS_ACKD;
               end
            end
            RS_ACKD: begin
               if (scl_fall) begin
                  sda_pull <= 1'b0;
                  scl_pull <= 1'b1;
                  state_q  <= RS_HOLD;
               end
            end
            RS_HOLD: begin
               if (tx_mode && wr_stb) begin
                  sh_q     <= wr_data;
                  cnt_q    <= '0;
                  scl_pull <= 1'b0;
                  sda_pull <= ~wr_data[BYTE_W-1];
                  state_q  <= RS_TX;
               end else if (!tx_mode && rd_stb) begin
                  cnt_q    <= '0;
                  scl_pull <= 1'b0;
                  state_q  <= RS_RX;
               end
            end
            RS_RX: begin
               if (scl_rise) begin
                  sh_q <= shifted;
                  if (cnt_q == LAST) begin
                     rd_data <= shifted;
                     cnt_q   <= '0;
                     state_q <= RS_ACKW;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            RS_TX: begin
               if (scl_fall) begin
                  if (cnt_q == LAST) begin
                     sda_pull <= 1'b0;
                     cnt_q    <= '0;
                     state_q  <= RS_TACK;
                  end else begin
                     sh_q     <= {sh_q[BYTE_W-2:0], sh_q[BYTE_W-1]};
                     sda_pull <= ~sh_q[BYTE_W-2];
                     cnt_q    <= cnt_q + 1'b1;
                  end
               end
            end
            RS_TACK: begin
               if (scl_rise) begin
                  nack <= sda_lvl;
               end else if (scl_fall) begin
                  if (nack) begin
                     tx_mode <= 1'b0;
                     state_q <= RS_WAIT;
                  end else begin
                     scl_pull <= 1'b1;
                     state_q  <= RS_HOLD;
                  end
               end
            end
            default: state_q <= RS_WAIT;
         endcase
      end
   end

endmodule

// File: rtl/i2cs_addr_resp.sv
module i2cs_addr_resp
   import i2cs_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYC    = 2,
   parameter int BYTE_W      = 8,
   parameter int ADDR_W      = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_pull_o,
   output logic              sda_pull_o,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              wr_stb_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   input  logic              rd_stb_i,
   output logic [BYTE_W-1:0] rd_data_o,
   output logic [7:0]        status_o,
   output logic              irq_o
);

   localparam int NLINES = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_CYC < 0) begin : g_bad_filt
      $error("FILT_CYC must not be negative");
   end
   if (ADDR_W != BYTE_W - 1) begin : g_bad_addr
      $error("ADDR_W must be BYTE_W - 1");
   end

   logic [NLINES-1:0] raw_w;
   logic [NLINES-1:0] cln_w;
   logic scl_rise, scl_fall, start_det, stop_det;
   logic selected, dir_tx, tx_mode, nack, irq;

   assign raw_w = {sda_i, scl_i};

   for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
      i2cs_line_cond #(
         .SYNC_STAGES(SYNC_STAGES),
         .FILT_CYC   (FILT_CYC)
      ) u_cond (
         .clk   (clk),
         .rst_n (rst_n),
         .line_i(raw_w[gi]),
         .line_o(cln_w[gi])
      );
   end

   i2cs_bus_events u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_c    (cln_w[0]),
      .sda_c    (cln_w[1]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   i2cs_byte_fsm #(
      .BYTE_W(BYTE_W),
      .ADDR_W(ADDR_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det),
      .sda_lvl  (cln_w[1]),
      .own_addr (own_addr_i),
      .wr_stb   (wr_stb_i),
      .wr_data  (wr_data_i),
      .rd_stb   (rd_stb_i),
      .rd_data  (rd_data_o),
      .scl_pull (scl_pull_o),
      .sda_pull (sda_pull_o),
      .selected (selected),
      .dir_tx   (dir_tx),
      .tx_mode  (tx_mode),
      .nack     (nack),
      .irq      (irq)
   );

   always_comb begin
      status_o          = '0;
      status_o[STB_SEL] = selected;
      status_o[STB_TXM] = tx_mode;
      status_o[STB_DIR] = dir_tx;
      status_o[STB_IRQ] = irq;
      status_o[STB_NACK] = nack;
   end

   assign irq_o = irq;

endmodule

// File: rtl/i2cs_addr_resp_chk.sv
module i2cs_addr_resp_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_stb_i,
   input logic rd_stb_i,
   input logic scl_pull_o,
   input logic sda_pull_o,
   input logic sel_bit,
   input logic dir_bit,
   input logic nack_bit,
   input logic irq_o
);

   // R5: a held clock stays held until software touches the data register
   a_r5_hold_until_access: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_pull_o && !wr_stb_i && !rd_stb_i) |=> scl_pull_o);

   // R5: the clock is only stretched while selected
   a_r5_hold_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
      scl_pull_o |-> sel_bit);

   // R3: data line is never pulled unless selected
   a_r3_sda_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
      sda_pull_o |-> sel_bit);

   // R4: direction stays put while selection persists
   a_r4_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_bit && $past(sel_bit)) |-> $stable(dir_bit));

   // R10: a new interrupt comes with a stretch or a missing acknowledge
   a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> (scl_pull_o || nack_bit));

endmodule

bind i2cs_addr_resp i2cs_addr_resp_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_stb_i  (wr_stb_i),
   .rd_stb_i  (rd_stb_i),
   .scl_pull_o(scl_pull_o),
   .sda_pull_o(sda_pull_o),
   .sel_bit   (status_o[6]),
   .dir_bit   (status_o[2]),
   .nack_bit  (status_o[0]),
   .irq_o     (irq_o)
);

// File: tb/sim_i2cs_addr_resp.sv
module sim_i2cs_addr_resp;

   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       scl_pull, sda_pull;
   logic       scl_bus, sda_bus;
   logic [6:0] own = 7'h00;
   logic       wr_stb = 1'b0;
   logic       rd_stb = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic [7:0] status;
   logic       irq;
   int         n_run = 0;
   int         n_fail = 0;
   bit         finished = 1'b0;

   always #4 clk = ~clk;

   assign scl_bus = scl_m & ~scl_pull;
   assign sda_bus = sda_m & ~sda_pull;

   i2cs_addr_resp u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_bus),
      .sda_i     (sda_bus),
      .scl_pull_o(scl_pull),
      .sda_pull_o(sda_pull),
      .own_addr_i(own),
      .wr_stb_i  (wr_stb),
      .wr_data_i (wr_data),
      .rd_stb_i  (rd_stb),
      .rd_data_o (rd_data),
      .status_o  (status),
      .irq_o     (irq)
   );

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wait_scl_high();
      while (scl_bus !== 1'b1) @(negedge clk);
   endtask

   task automatic m_start();
      sda_m = 1'b1; wait_cyc(Q);
      scl_m = 1'b1; wait_scl_high(); wait_cyc(Q);
      sda_m = 1'b0; wait_cyc(Q);
      scl_m = 1'b0; wait_cyc(Q);
   endtask

   task automatic m_stop();
      sda_m = 1'b0; wait_cyc(Q);
      scl_m = 1'b1; wait_scl_high(); wait_cyc(Q);
      sda_m = 1'b1; wait_cyc(Q);
   endtask

   task automatic m_clock(input logic b, output logic r);
      sda_m = b; wait_cyc(Q);
      scl_m = 1'b1; wait_scl_high(); wait_cyc(Q);
      r = sda_bus; wait_cyc(Q);
      scl_m = 1'b0; wait_cyc(Q);
   endtask

   task automatic m_send(input logic [7:0] b, output logic ack_bit);
      logic r;
      for (int i = 7; i >= 0; i--) m_clock(b[i], r);
      m_clock(1'b1, ack_bit);
   endtask

   task automatic m_recv(input logic ack_in, output logic [7:0] d);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         m_clock(1'b1, r);
         d[i] = r;
      end
      m_clock(ack_in, r);
      sda_m = 1'b1;
   endtask

   task automatic sw_read(output logic [7:0] d);
      @(negedge clk);
      rd_stb = 1'b1;
      d = rd_data;
      @(negedge clk);
      rd_stb = 1'b0;
      wait_cyc(2);
   endtask

   task automatic sw_write(input logic [7:0] d);
      @(negedge clk);
      wr_stb = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_stb = 1'b0;
      wait_cyc(2);
   endtask

   task automatic check_stretch(input string req);
      check(req, "scl pull after byte", 32'(scl_pull), 32'd1);
      scl_m = 1'b1;
      wait_cyc(40);
      check(req, "bus clock held low", 32'(scl_bus), 32'd0);
      scl_m = 1'b0;
      wait_cyc(2);
   endtask

   task automatic t_reset();
      check("R1", "status", 32'(status), 32'h00);
      check("R1", "irq", 32'(irq), 32'd0);
      check("R1", "scl pull", 32'(scl_pull), 32'd0);
      check("R1", "sda pull", 32'(sda_pull), 32'd0);
   endtask

   task automatic t_write_block();
      logic       a;
      logic [7:0] d;
      own = 7'h33;
      m_start();
      m_send(8'h66, a);
      check("R2", "address ack", 32'(a), 32'd0);
      check("R2", "selected bit6", 32'(status[6]), 32'd1);
      check("R4", "direction bit2", 32'(status[2]), 32'd0);
      check("R10", "irq after address", 32'(irq), 32'd1);
      check_stretch("R5");
      sw_write(8'hFF);
      check("R5", "write ignored in receive hold", 32'(scl_pull), 32'd1);
      check("R10", "irq cleared by access", 32'(irq), 32'd0);
      sw_read(d);
      check("R5", "dummy read releases clock", 32'(scl_pull), 32'd0);
      m_send(8'hA5, a);
      check("R6", "data ack 1", 32'(a), 32'd0);
      check("R10", "irq after data", 32'(irq), 32'd1);
      sw_read(d);
      check("R6", "data 1", 32'(d), 32'hA5);
      m_send(8'h3C, a);
      check("R6", "data ack 2", 32'(a), 32'd0);
      sw_read(d);
      check("R6", "data 2", 32'(d), 32'h3C);
      m_stop();
      check("R9", "stop clears selected", 32'(status[6]), 32'd0);
   endtask

   task automatic t_mismatch();
      logic a;
      own = 7'h33;
      m_start();
      m_send(8'h68, a);
      check("R3", "no address ack", 32'(a), 32'd1);
      check("R3", "not selected", 32'(status[6]), 32'd0);
      check("R3", "no irq", 32'(irq), 32'd0);
      m_send(8'h11, a);
      check("R3", "data ignored", 32'(a), 32'd1);
      check("R3", "no stretch", 32'(scl_pull), 32'd0);
      m_stop();
   endtask

   task automatic t_read_block();
      logic       a;
      logic [7:0] d;
      own = 7'h7F;
      m_start();
      m_send(8'hFF, a);
      check("R2", "read address ack", 32'(a), 32'd0);
      check("R4", "direction transmit", 32'(status[2]), 32'd1);
      check("R7", "transmit mode bit4", 32'(status[4]), 32'd1);
      sw_write(8'h96);
      m_recv(1'b0, d);
      check("R7", "byte 1 on wire", 32'(d), 32'h96);
      check("R7", "hold after master ack", 32'(scl_pull), 32'd1);
      sw_read(d);
      check("R5", "read ignored in transmit hold", 32'(scl_pull), 32'd1);
      sw_write(8'h5A);
      m_recv(1'b1, d);
      check("R7", "byte 2 on wire", 32'(d), 32'h5A);
      check("R8", "nack bit0", 32'(status[0]), 32'd1);
      check("R8", "irq on nack", 32'(irq), 32'd1);
      check("R8", "no stretch on nack", 32'(scl_pull), 32'd0);
      check("R8", "back to receive mode", 32'(status[4]), 32'd0);
      check("R8", "sda released", 32'(sda_pull), 32'd0);
      m_stop();
      check("R9", "stop clears selected", 32'(status[6]), 32'd0);
      sw_read(d);
   endtask

   task automatic t_restart_zero();
      logic       a;
      logic [7:0] d;
      own = 7'h00;
      m_start();
      m_send(8'h80, a);
      check("R3", "address 0x40 vs own 0", 32'(a), 32'd1);
      m_start();
      m_send(8'h00, a);
      check("R2", "address 0 after repeated start", 32'(a), 32'd0);
      check("R2", "selected after restart", 32'(status[6]), 32'd1);
      sw_read(d);
      m_send(8'h7E, a);
      check("R6", "ack with address 0", 32'(a), 32'd0);
      sw_read(d);
      check("R6", "data with address 0", 32'(d), 32'h7E);
      m_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(5);
      t_reset();
      t_write_block();
      t_mismatch();
      t_read_block();
      t_restart_zero();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule